// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block translates the virtual addresses of one access stream, either instruction fetches or data accesses, into physical addresses. It holds up to 32 page translations, and any translation may sit in any slot. An accepted request that matches a resident page returns the physical address, the domain number and the attribute bits one cycle later. A request that matches no slot stalls the stream and raises a refill request carrying the virtual page number. It then waits for a descriptor on the refill port, stores the descriptor in a victim slot and completes the stalled access from that descriptor.

Every translated access is also checked against a table of 16 two-bit domain controls. A violation returns an abort in place of the translation. A count of locked low slots keeps chosen translations resident against replacement and against invalidate-all. Victim selection steps round-robin through the unlocked slots only. When the global enable is low, the block passes addresses through unchanged.

Top module: `lock_tlb`

## Requirements
- R1: The buffer compares a request's page number (address bits 31:12) against all 32 slots in parallel. A match returns rsp_vld one cycle after acceptance, with no refill. The response carries rsp_pa = {stored physical page, address bits 11:0}, the stored domain and the stored attribute bits.
- R2: A translated request that matches no valid slot raises refill_req one cycle after acceptance, with refill_vpn equal to the page number. Both are held until refill_vld, and req_rdy stays low for that whole time.
- R3: In the cycle refill_vld is sampled, the descriptor is written into the victim slot. The stalled access responds from that descriptor one cycle later, and later requests to the same page hit.
- R4: Victims are chosen round-robin. The victim is the pointer, or the first unlocked slot when the pointer lies below it. After each refill the pointer moves to victim+1, and it wraps from slot 31 back to the first unlocked slot. The pointer resets to 0.
- R5: lock_cnt = N locks slots 0 to N-1 (N at most 31). Locked slots are never victims, so slot 31 can always be replaced.
- R6: A flush_all pulse clears every slot at or above lock_cnt and leaves the locked slots resident. A refill written in the same cycle survives the flush.
- R7: The domain control of domain d is dom_ctl[2d+1:2d]. Code 00 always aborts, code 01 (client) checks the permission bits, code 10 is reserved and aborts, and code 11 (manager) never aborts.
- R8: For client domains, permission bit 0 of a slot allows writes and permission bit 1 allows unprivileged access. A write without bit 0 aborts, and an unprivileged access without bit 1 aborts.
- R9: An aborted access returns rsp_vld with rsp_abort=1, rsp_pa=0, rsp_attr=0 and the slot's domain in rsp_dom.
- R10: With xlate_en low, an accepted request responds one cycle later with rsp_pa equal to the address, rsp_dom=0, rsp_attr=0 and no abort, whatever the domain controls hold. It raises no refill.
- R11: After reset no slot is valid, req_rdy is high, and rsp_vld and refill_req are low.
- R12: rsp_vld and refill_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation and permission checking enable |
| lock_cnt | input | 5 | Number of locked low slots |
| flush_all | input | 1 | Invalidate all unlocked slots |
| dom_ctl | input | 32 | Two-bit control per domain |
| req_vld | input | 1 | Request valid |
| req_rdy | output | 1 | Request can be accepted |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| refill_req | output | 1 | Descriptor needed |
| refill_vpn | output | 20 | Page number to be refilled |
| refill_vld | input | 1 | Descriptor present |
| refill_ppn | input | 20 | Descriptor physical page |
| refill_ap | input | 2 | Descriptor permission bits |
| refill_dom | input | 4 | Descriptor domain |
| refill_attr | input | 4 | Descriptor attribute bits |
| rsp_vld | output | 1 | Response valid |
| rsp_pa | output | 32 | Physical address |
| rsp_dom | output | 4 | Domain of the translation |
| rsp_attr | output | 4 | Attribute bits |
| rsp_abort | output | 1 | Permission violation |

## Verification
On every cycle the assertions check several properties. At most one slot may match. A response and a refill request are never raised together. An abort response always carries a cleared address and cleared attributes. A pending refill keeps its page number stable with the request port closed. Every refill ends in a response, and no refill victim is a locked slot. The passthrough response is checked against the delayed address. Which slot a refill replaces, and whether a slot survives a flush or a lock change, shows only through later hits and misses. The bench therefore runs long access sequences against an arithmetic model of slot contents and pointer, and it sweeps all domain codes, permission bits, write and privilege combinations.

// File: rtl/lock_tlb.sv
module lock_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W = 32,
  parameter int PG_W = 12,
  parameter int DOMS = 16,
  parameter int ATTR_W = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - PG_W,
  localparam int DOM_W = $clog2(DOMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic [IDX_W-1:0]  lock_cnt,
  input  logic              flush_all,
  input  logic [2*DOMS-1:0] dom_ctl,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_wr,
  input  logic              req_priv,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  input  logic              refill_vld,
  input  logic [VPN_W-1:0]  refill_ppn,
  input  logic [1:0]        refill_ap,
  input  logic [DOM_W-1:0]  refill_dom,
  input  logic [ATTR_W-1:0] refill_attr,
  output logic              rsp_vld,
  output logic [VA_W-1:0]   rsp_pa,
  output logic [DOM_W-1:0]  rsp_dom,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              rsp_abort
);

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [VPN_W-1:0]   ppn_q  [ENTRIES];
  logic [1:0]         ap_q   [ENTRIES];
  logic [DOM_W-1:0]   dom_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];

  logic [VA_W-1:0]  hold_va;
  logic             hold_wr, hold_priv;
  logic [IDX_W-1:0] rr_ptr, lock_eff, victim, ptr_nx;

  logic [ENTRIES-1:0] hit_vec;
  logic               hit;
  logic [VPN_W-1:0]   sel_ppn;
  logic [1:0]         sel_ap;
  logic [DOM_W-1:0]   sel_dom;
  logic [ATTR_W-1:0]  sel_attr;

  wire [VPN_W-1:0] req_vpn = req_va[VA_W-1:PG_W];
  wire accept    = req_vld && st == S_IDLE;
  wire from_fill = st == S_WAIT && refill_vld;

  assign req_rdy    = st == S_IDLE;
  assign refill_req = st == S_WAIT;
  assign refill_vpn = hold_va[VA_W-1:PG_W];

  assign lock_eff = (int'(lock_cnt) > ENTRIES - 1) ? IDX_W'(ENTRIES - 1) : lock_cnt;
  assign victim   = (rr_ptr < lock_eff) ? lock_eff : rr_ptr;
  assign ptr_nx   = (victim == IDX_W'(ENTRIES - 1)) ? lock_eff : victim + 1'b1;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && tag_q[g] == req_vpn;
  end
  assign hit = |hit_vec;

  always_comb begin
    sel_ppn = '0; sel_ap = '0; sel_dom = '0; sel_attr = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) begin
        sel_ppn  |= ppn_q[i];
        sel_ap   |= ap_q[i];
        sel_dom  |= dom_q[i];
        sel_attr |= attr_q[i];
      end
  end

  wire [VPN_W-1:0]  src_ppn  = from_fill ? refill_ppn  : sel_ppn;
  wire [1:0]        src_ap   = from_fill ? refill_ap   : sel_ap;
  wire [DOM_W-1:0]  src_dom  = from_fill ? refill_dom  : sel_dom;
  wire [ATTR_W-1:0] src_attr = from_fill ? refill_attr : sel_attr;
  wire [PG_W-1:0]   src_off  = from_fill ? hold_va[PG_W-1:0] : req_va[PG_W-1:0];
  wire              src_wr   = from_fill ? hold_wr   : req_wr;
  wire              src_priv = from_fill ? hold_priv : req_priv;
  wire [1:0]        code     = dom_ctl[2*int'(src_dom) +: 2];

  logic fault;
  always_comb
    case (code)
      2'b01:   fault = (src_wr && !src_ap[0]) || (!src_priv && !src_ap[1]);
      2'b11:   fault = 1'b0;
      default: fault = 1'b1;
    endcase

  wire translate = from_fill || (accept && xlate_en && hit);
  wire passthru  = accept && !xlate_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld       <= '0;
      rr_ptr    <= '0;
      hold_va   <= '0;
      hold_wr   <= 1'b0;
      hold_priv <= 1'b0;
      rsp_vld   <= 1'b0;
      rsp_pa    <= '0;
      rsp_dom   <= '0;
      rsp_attr  <= '0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_vld   <= translate || passthru;
      rsp_abort <= translate && fault;
      rsp_pa    <= passthru ? req_va :
                   (translate && !fault) ? {src_ppn, src_off} : '0;
      rsp_dom   <= translate ? src_dom : '0;
      rsp_attr  <= (translate && !fault) ? src_attr : '0;
      for (int i = 0; i < ENTRIES; i++)
        if (flush_all && IDX_W'(i) >= lock_eff) vld[i] <= 1'b0;
      if (accept && xlate_en && !hit) begin
        st        <= S_WAIT;
        hold_va   <= req_va;
        hold_wr   <= req_wr;
        hold_priv <= req_priv;
      end
      if (from_fill) begin
        st          <= S_IDLE;
        vld[victim] <= 1'b1;
        rr_ptr      <= ptr_nx;
      end
    end
  end

  always_ff @(posedge clk)
    if (from_fill) begin
      tag_q[victim]  <= hold_va[VA_W-1:PG_W];
      ppn_q[victim]  <= refill_ppn;
      ap_q[victim]   <= refill_ap;
      dom_q[victim]  <= refill_dom;
      attr_q[victim] <= refill_attr;
    end

endmodule

// File: rtl/lock_tlb_chk.sv
module lock_tlb_chk #(
  parameter int ENTRIES = 32,
  parameter int VA_W = 32,
  parameter int PG_W = 12,
  parameter int ATTR_W = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - PG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlate_en,
  input logic              req_vld,
  input logic              req_rdy,
  input logic [VA_W-1:0]   req_va,
  input logic              refill_req,
  input logic [VPN_W-1:0]  refill_vpn,
  input logic              refill_vld,
  input logic              rsp_vld,
  input logic [VA_W-1:0]   rsp_pa,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic              rsp_abort,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [IDX_W-1:0]  victim,
  input logic [IDX_W-1:0]  lock_eff
);

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

  // R12
  rsp_refill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_vld && refill_req));

  // R9
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> rsp_vld && rsp_pa == '0 && rsp_attr == '0);

  // R10
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_rdy && !xlate_en |=> rsp_vld && !rsp_abort && rsp_pa == $past(req_va));

  // R2
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && !refill_vld |=> refill_req && $stable(refill_vpn));

  // R2
  stall_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n) refill_req |-> !req_rdy);

  // R3
  refill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && refill_vld |=> rsp_vld && !refill_req);

  // R5
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && refill_vld |-> victim >= lock_eff);

endmodule

bind lock_tlb lock_tlb_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PG_W(PG_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .req_vld(req_vld), .req_rdy(req_rdy),
  .req_va(req_va), .refill_req(refill_req), .refill_vpn(refill_vpn), .refill_vld(refill_vld),
  .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_abort(rsp_abort),
  .hit_vec(hit_vec), .victim(victim), .lock_eff(lock_eff)
);

// File: tb/lock_tlb_bench.sv
`timescale 1ns/1ps
module lock_tlb_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        xlate_en = 0, flush_all = 0, req_vld = 0, req_wr = 0, req_priv = 0, refill_vld = 0;
  logic [4:0]  lock_cnt = 0;
  logic [31:0] dom_ctl = 0, req_va = 0;
  logic [19:0] refill_ppn = 0;
  logic [1:0]  refill_ap = 0;
  logic [3:0]  refill_dom = 0, refill_attr = 0;
  logic        req_rdy, refill_req, rsp_vld, rsp_abort;
  logic [19:0] refill_vpn;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_dom, rsp_attr;

  lock_tlb u_lock_tlb (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lock_cnt(lock_cnt), .flush_all(flush_all),
    .dom_ctl(dom_ctl), .req_vld(req_vld), .req_rdy(req_rdy), .req_va(req_va), .req_wr(req_wr),
    .req_priv(req_priv), .refill_req(refill_req), .refill_vpn(refill_vpn), .refill_vld(refill_vld),
    .refill_ppn(refill_ppn), .refill_ap(refill_ap), .refill_dom(refill_dom),
    .refill_attr(refill_attr), .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_dom(rsp_dom),
    .rsp_attr(rsp_attr), .rsp_abort(rsp_abort));

  int total = 0, bad = 0;
  bit finished = 0;

  bit        m_v [32];
  bit [19:0] m_tag [32];
  int        m_ptr = 0;

  task automatic check(bit ok, string rq, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit [19:0] d_ppn(bit [19:0] v); return v ^ 20'hA5A5A; endfunction
  function automatic bit [1:0]  d_ap(bit [19:0] v);  return v[1:0]; endfunction
  function automatic bit [3:0]  d_dom(bit [19:0] v); return v[5:2]; endfunction
  function automatic bit [3:0]  d_attr(bit [19:0] v); return v[9:6]; endfunction

  function automatic bit exp_abort(bit [19:0] v, bit wr, bit priv);
    bit [1:0] c = dom_ctl[2*d_dom(v) +: 2];
    bit [1:0] ap = d_ap(v);
    if (c == 2'b11) return 0;
    if (c == 2'b01) return (wr && !ap[0]) || (!priv && !ap[1]);
    return 1;
  endfunction

  function automatic int lk();
    return (int'(lock_cnt) > 31) ? 31 : int'(lock_cnt);
  endfunction

  function automatic bit m_hit(bit [19:0] v);
    for (int i = 0; i < 32; i++) if (m_v[i] && m_tag[i] == v) return 1;
    return 0;
  endfunction

  task automatic check_rsp(bit [31:0] va, bit wr, bit priv, string rq);
    bit [19:0] v = va[31:12];
    bit ab = exp_abort(v, wr, priv);
    bit [31:0] epa = ab ? 32'h0 : {d_ppn(v), va[11:0]};
    check(rsp_vld == 1, rq, rsp_vld, 1);
    check(rsp_abort == ab, {rq, "/R7/R8 abort"}, rsp_abort, ab);
    check(rsp_pa == epa, {rq, "/R9 pa"}, rsp_pa, epa);
    check(rsp_dom == d_dom(v), {rq, " dom"}, rsp_dom, d_dom(v));
    check(rsp_attr == (ab ? 4'h0 : d_attr(v)), {rq, " attr"}, rsp_attr, ab ? 0 : d_attr(v));
  endtask

  task automatic access(bit [31:0] va, bit wr, bit priv, string rq);
    bit [19:0] v = va[31:12];
    @(negedge clk);
    req_vld = 1; req_va = va; req_wr = wr; req_priv = priv;
    @(negedge clk);
    req_vld = 0;
    if (!xlate_en) begin
      check(rsp_vld && !refill_req, {rq, " R10 passthru vld"}, {refill_req, rsp_vld}, 1);
      check(rsp_pa == va && !rsp_abort, {rq, " R10 pa"}, rsp_pa, va);
      check(rsp_dom == 0 && rsp_attr == 0, {rq, " R10 dom/attr"}, {rsp_dom, rsp_attr}, 0);
    end else if (m_hit(v)) begin
      check(!refill_req, {rq, " R1 no refill on hit"}, refill_req, 0);
      check_rsp(va, wr, priv, {rq, " R1 hit"});
    end else begin
      int vic;
      check(refill_req && !rsp_vld, {rq, " R2 miss"}, {refill_req, rsp_vld}, 2);
      check(refill_vpn == v && !req_rdy, {rq, " R2 vpn"}, refill_vpn, v);
      @(negedge clk);
      check(refill_req && refill_vpn == v, {rq, " R2 held"}, refill_req, 1);
      refill_vld = 1; refill_ppn = d_ppn(v); refill_ap = d_ap(v);
      refill_dom = d_dom(v); refill_attr = d_attr(v);
      @(negedge clk);
      refill_vld = 0;
      check(!refill_req && req_rdy, {rq, " R3 refill done"}, refill_req, 0);
      check_rsp(va, wr, priv, {rq, " R3 fill rsp"});
      vic = (m_ptr < lk()) ? lk() : m_ptr;
      m_v[vic] = 1; m_tag[vic] = v;
      m_ptr = (vic == 31) ? lk() : vic + 1;
    end
  endtask

  task automatic flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    for (int i = lk(); i < 32; i++) m_v[i] = 0;
  endtask

  initial begin
    #1_200_000;
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_rdy && !rsp_vld && !refill_req, "R11 reset outputs", {req_rdy, rsp_vld, refill_req}, 4);

    // passthrough with every domain set to no-access
    dom_ctl = 32'h0;
    for (int i = 0; i < 16; i++) access(32'h1357_0000 * i + i * 33, i[0], i[1], "R10");

    // R11: all slots empty after reset, so the first sweep misses everywhere
    xlate_en = 1; dom_ctl = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) access({20'(i), 12'(i * 97)}, i[0], 0, "R11/R1");
    for (int i = 0; i < 32; i++) access({20'(i), 12'(i * 13)}, 1, 1, "R1");
    // R4: wrap-around replacement
    for (int i = 32; i < 40; i++) access({20'(i), 12'h0}, 0, 1, "R4");
    for (int i = 0; i < 12; i++) access({20'(i), 12'h1}, 0, 1, "R4");

    // R5: lock four, replace, then all locked but the top slot
    lock_cnt = 4;
    for (int i = 40; i < 100; i++) access({20'(i % 70), 12'h2}, 0, 1, "R5");
    lock_cnt = 31;
    for (int i = 100; i < 106; i++) access({20'(i), 12'h3}, 0, 1, "R5");
    for (int i = 0; i < 100; i += 3) access({20'(i), 12'h4}, 1, 1, "R5");

    // R6: flush keeps locked slots
    lock_cnt = 4;
    flush();
    for (int i = 0; i < 110; i += 2) access({20'(i), 12'h5}, 0, 1, "R6");
    lock_cnt = 0;
    flush();

    // R7/R8/R9: domain d uses code d mod 4
    for (int d = 0; d < 16; d++) dom_ctl[2*d +: 2] = 2'(d);
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) access({20'(i), 12'(k)}, k[0], k[1], "R7/R8/R9");

    // R12 is checked throughout by sampling: a clean idle cycle
    @(negedge clk);
    check(!(rsp_vld && refill_req), "R12 exclusive", {rsp_vld, refill_req}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule